// File: doc/BRIEF.md
# Multi-format audio serial data transmitter

This block is a slave-mode serial audio transmitter. Parallel PCM samples are offered on a wide bus with a valid/ready handshake. A bit clock and a frame clock arrive from outside and are oversampled by the system clock. The samples are shifted out MSB first on a single serial data line. One shifter handles three stereo framings (I2S, left-justified and right-justified), a DSP framing with a pulse per word, and a TDM framing with 4, 8 or 16 slots of 32 bit clocks each. The word width is 24, 20 or 16 bits.

The bit clock and the frame clock pass through two-flop synchronizers. All framing is decided at each falling edge of the bit clock, and the serial line is updated there, so that a receiver can sample it on the rising edge.

A sample is taken from a single holding register at the start of each frame. If no sample is waiting at that point, the previous one is sent again and a sticky underrun flag is raised.

The configuration inputs are registered every system cycle. They should change only while the bit clock is paused between frames.

Top module: `aud_ser_tx`

## Requirements
- R1: While reset is asserted and after reset, `sdata_o` is 0, `smp_ready_o` is 1 and `underrun_o` is 0. The all-zero configuration (format code 0, width code 0) selects I2S framing with 24-bit words.
- R2: Channel c of the sample bus occupies bits [24c+23:24c], with the word's MSB at bit 24c+23. `smp_ready_o` is 1 exactly when the holding register is empty, and it drops in the cycle after a transfer. A transfer occurs when `smp_valid_i` and `smp_ready_o` are both 1 at a clock edge. The held sample is consumed at the next frame start, after which ready returns to 1.
- R3: Format code 0 (I2S): a frame clock low marks channel 0 and a high marks channel 1. Each level change starts a 32-bit half, and the MSB is sent at position 1 of the half. A frame starts on the change to low.
- R4: Format code 1 (left-justified): same halves as R3, with the MSB at position 0.
- R5: Format code 2 (right-justified): same halves as R3, with the MSB at position 32−W, so that the LSB lands at position 31.
- R6: Width code 0 selects W=24, code 1 selects W=20 and code 2 selects W=16. Only the upper W bits of each 24-bit field are sent. Every position outside a word is driven 0.
- R7: Format code 3 (DSP): each rising frame-clock edge starts a word, with the MSB at position 1. Words alternate between channel 0 and channel 1, starting with channel 0 after the format is selected. A frame starts at each channel-0 word.
- R8: Format code 4 (TDM): a rising frame-clock edge starts a frame. Slot s carries channel s, with its MSB at position 32s+1. Slot code 0 gives 4 slots, code 1 gives 8 and codes 2–3 give 16. Slots at or beyond the count are 0.
- R9: `sdata_o` changes only in the cycle after a falling edge of the bit clock has been detected, and it is stable across the high phase.
- R10: A bit clock that pauses between frames for any number of system cycles does not disturb framing or data.
- R11: When no sample is held at a frame start, the previous sample is sent again and `underrun_o` is set. It stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bclk_i | input | 1 | External bit clock |
| fclk_i | input | 1 | External frame clock |
| fmt_i | input | 3 | Format code (0 I2S, 1 LJ, 2 RJ, 3 DSP, 4 TDM; others act as I2S) |
| width_i | input | 2 | Word width code (0: 24, 1: 20, 2: 16) |
| slots_i | input | 2 | TDM slot count code (0: 4, 1: 8, 2/3: 16) |
| smp_valid_i | input | 1 | Sample bus valid |
| smp_data_i | input | MAX_SLOTS*CH_W | Sample bus, one 24-bit field per channel |
| smp_ready_o | output | 1 | Holding register empty |
| sdata_o | output | 1 | Serial data out |
| underrun_o | output | 1 | Sticky underrun flag |

## Verification
The bench builds the block with its defaults: 24-bit channel fields, 16 slots of 32 bit clocks, and a two-stage synchronizer. These values bring the full 16-slot TDM frame of 512 bit clocks within reach, along with every combination of the three word widths and the right-justified start offsets. Each bit clock lasts 16 system cycles, so the synchronizer and output register latency fits well inside one low phase. Every frame is compared bit by bit against a model built from the requirements.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;
  typedef enum logic [2:0] {
    FMT_I2S = 3'd0,
    FMT_LJ  = 3'd1,
    FMT_RJ  = 3'd2,
    FMT_DSP = 3'd3,
    FMT_TDM = 3'd4
  } fmt_e;

  function automatic fmt_e fmt_decode(input logic [2:0] code);
    case (code)
      3'd1:    return FMT_LJ;
      3'd2:    return FMT_RJ;
      3'd3:    return FMT_DSP;
      3'd4:    return FMT_TDM;
      default: return FMT_I2S;
    endcase
  endfunction

  function automatic logic [4:0] word_bits(input logic [1:0] code);
    case (code)
      2'd1:    return 5'd20;
      2'd2:    return 5'd16;
      default: return 5'd24;
    endcase
  endfunction

  function automatic logic [4:0] slot_count(input logic [1:0] code);
    case (code)
      2'd0:    return 5'd4;
      2'd1:    return 5'd8;
      default: return 5'd16;
    endcase
  endfunction
endpackage

// File: rtl/aud_tx_edge_sync.sv
module aud_tx_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bclk_i,
  input  logic fclk_i,
  output logic fall_o,
  output logic fclk_o
);
  logic [STAGES-1:0] bsync_q, fsync_q;
  logic              bprev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bsync_q <= '0;
      fsync_q <= '0;
      bprev_q <= 1'b0;
    end else begin
      bsync_q <= {bsync_q[STAGES-2:0], bclk_i};
      fsync_q <= {fsync_q[STAGES-2:0], fclk_i};
      bprev_q <= bsync_q[STAGES-1];
    end
  end

  assign fall_o = bprev_q & ~bsync_q[STAGES-1];
  assign fclk_o = fsync_q[STAGES-1];
endmodule

// File: rtl/aud_tx_framer.sv
module aud_tx_framer
  import aud_tx_pkg::*;
#(
  parameter int POS_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fall_i,
  input  logic             fclk_i,
  input  fmt_e             fmt_i,
  output logic             load_o,
  output logic [POS_W-1:0] pos_o,
  output logic             seg_ch_o
);
  logic             fclk_prev_q, dsp_right_q, seg_ch_q;
  logic [POS_W-1:0] pos_q;
  logic             stereo, rise, fell, seg_start;

  always_comb begin
    stereo    = (fmt_i == FMT_I2S) || (fmt_i == FMT_LJ) || (fmt_i == FMT_RJ);
    rise      = fclk_i & ~fclk_prev_q;
    fell      = ~fclk_i & fclk_prev_q;
    seg_start = stereo ? (rise | fell) : rise;
    if (stereo) load_o = fall_i & fell;
    else        load_o = fall_i & rise & ((fmt_i != FMT_DSP) | ~dsp_right_q);
    pos_o     = seg_start ? '0 : ((&pos_q) ? pos_q : pos_q + 1'b1);
    if (stereo)                seg_ch_o = fclk_i;
    else if (fmt_i == FMT_DSP) seg_ch_o = seg_start ? dsp_right_q : seg_ch_q;
    else                       seg_ch_o = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fclk_prev_q <= 1'b0;
      pos_q       <= '0;
      seg_ch_q    <= 1'b0;
      dsp_right_q <= 1'b0;
    end else begin
      if (fmt_i != FMT_DSP)        dsp_right_q <= 1'b0;
      else if (fall_i && rise)     dsp_right_q <= ~dsp_right_q;
      if (fall_i) begin
        fclk_prev_q <= fclk_i;
        pos_q       <= pos_o;
        seg_ch_q    <= seg_ch_o;
      end
    end
  end
endmodule

// File: rtl/aud_tx_sample_buf.sv
module aud_tx_sample_buf #(
  parameter int BUS_W = 384
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [BUS_W-1:0] data_i,
  input  logic             load_i,
  output logic             ready_o,
  output logic             pend_full_o,
  output logic [BUS_W-1:0] src_o,
  output logic             underrun_o
);
  logic [BUS_W-1:0] pend_q, cur_q;
  logic             pend_full_q, underrun_q;

  assign ready_o     = ~pend_full_q;
  assign pend_full_o = pend_full_q;
  assign underrun_o  = underrun_q;
  // frame start uses the incoming sample in the same bit slot
  assign src_o = (load_i && pend_full_q) ? pend_q : cur_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q      <= '0;
      cur_q       <= '0;
      pend_full_q <= 1'b0;
      underrun_q  <= 1'b0;
    end else begin
      if (valid_i && !pend_full_q) begin
        pend_q      <= data_i;
        pend_full_q <= 1'b1;
      end
      if (load_i) begin
        if (pend_full_q) begin
          cur_q       <= pend_q;
          pend_full_q <= 1'b0;
        end else begin
          underrun_q  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/aud_tx_bitsel.sv
module aud_tx_bitsel
  import aud_tx_pkg::*;
#(
  parameter int CH_W      = 24,
  parameter int MAX_SLOTS = 16,
  parameter int SLOT_BITS = 32,
  parameter int POS_W     = 10
) (
  input  fmt_e                          fmt_i,
  input  logic [1:0]                    wcode_i,
  input  logic [1:0]                    scode_i,
  input  logic [POS_W-1:0]              pos_i,
  input  logic                          seg_ch_i,
  input  logic [MAX_SLOTS*CH_W-1:0]     smp_i,
  output logic                          bit_o
);
  localparam int SLOT_LG  = $clog2(SLOT_BITS);
  localparam int SL_W     = POS_W - SLOT_LG;
  localparam int CH_IDX_W = $clog2(MAX_SLOTS);
  localparam int IDX_W    = $clog2(MAX_SLOTS*CH_W);

  logic [4:0]          wb;
  logic [POS_W-1:0]    d, q;
  logic [SL_W-1:0]     slot;
  logic [SLOT_LG-1:0]  k;
  logic [CH_IDX_W-1:0] ch;
  logic [IDX_W-1:0]    idx;
  logic                slot_ok;

  always_comb begin
    wb = word_bits(wcode_i);
    case (fmt_i)
      FMT_LJ:  d = '0;
      FMT_RJ:  d = POS_W'(SLOT_BITS) - POS_W'(wb);
      default: d = POS_W'(1);
    endcase
    q    = pos_i - d;
    slot = q[POS_W-1:SLOT_LG];
    k    = q[SLOT_LG-1:0];
    if (fmt_i == FMT_TDM) begin
      slot_ok = slot < SL_W'(slot_count(scode_i));
      ch      = slot[CH_IDX_W-1:0];
    end else begin
      slot_ok = (slot == '0);
      ch      = CH_IDX_W'(seg_ch_i);
    end
    idx   = IDX_W'(ch) * IDX_W'(CH_W) + IDX_W'(CH_W - 1) - IDX_W'(k);
    bit_o = ((pos_i >= d) && slot_ok && (int'(k) < int'(wb))) ? smp_i[idx] : 1'b0;
  end
endmodule

// File: rtl/aud_ser_tx.sv
module aud_ser_tx
  import aud_tx_pkg::*;
#(
  parameter int CH_W        = 24,
  parameter int MAX_SLOTS   = 16,
  parameter int SLOT_BITS   = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      bclk_i,
  input  logic                      fclk_i,
  input  logic [2:0]                fmt_i,
  input  logic [1:0]                width_i,
  input  logic [1:0]                slots_i,
  input  logic                      smp_valid_i,
  input  logic [MAX_SLOTS*CH_W-1:0] smp_data_i,
  output logic                      smp_ready_o,
  output logic                      sdata_o,
  output logic                      underrun_o
);
  localparam int BUS_W = MAX_SLOTS * CH_W;
  localparam int POS_W = $clog2(MAX_SLOTS * SLOT_BITS) + 1;

  fmt_e             fmt_q;
  logic [1:0]       wcode_q, scode_q;
  logic             fall_w, fclk_w, load_w, seg_ch_w, bit_w, pend_full_w, sdata_q;
  logic [POS_W-1:0] pos_w;
  logic [BUS_W-1:0] src_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fmt_q   <= FMT_I2S;
      wcode_q <= 2'd0;
      scode_q <= 2'd2;
      sdata_q <= 1'b0;
    end else begin
      fmt_q   <= fmt_decode(fmt_i);
      wcode_q <= width_i;
      scode_q <= slots_i;
      if (fall_w) sdata_q <= bit_w;
    end
  end

  aud_tx_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .bclk_i, .fclk_i, .fall_o(fall_w), .fclk_o(fclk_w)
  );

  aud_tx_framer #(.POS_W(POS_W)) u_framer (
    .clk_i, .rst_ni, .fall_i(fall_w), .fclk_i(fclk_w), .fmt_i(fmt_q),
    .load_o(load_w), .pos_o(pos_w), .seg_ch_o(seg_ch_w)
  );

  aud_tx_sample_buf #(.BUS_W(BUS_W)) u_buf (
    .clk_i, .rst_ni, .valid_i(smp_valid_i), .data_i(smp_data_i), .load_i(load_w),
    .ready_o(smp_ready_o), .pend_full_o(pend_full_w), .src_o(src_w),
    .underrun_o(underrun_o)
  );

  aud_tx_bitsel #(
    .CH_W(CH_W), .MAX_SLOTS(MAX_SLOTS), .SLOT_BITS(SLOT_BITS), .POS_W(POS_W)
  ) u_bitsel (
    .fmt_i(fmt_q), .wcode_i(wcode_q), .scode_i(scode_q), .pos_i(pos_w),
    .seg_ch_i(seg_ch_w), .smp_i(src_w), .bit_o(bit_w)
  );

  assign sdata_o = sdata_q;
endmodule

// File: rtl/aud_ser_tx_chk.sv
module aud_ser_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic fall_i,
  input logic load_i,
  input logic pend_full_i,
  input logic sdata_i,
  input logic valid_i,
  input logic ready_i,
  input logic underrun_i
);
  assert_sdata_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(fall_i) |-> $stable(sdata_i));

  assert_ready_drop_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_i) |=> !ready_i);

  assert_load_on_fall_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> fall_i);

  assert_underrun_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_i |=> underrun_i);

  assert_underrun_cause_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(underrun_i) |-> $past(load_i && !pend_full_i));
endmodule

bind aud_ser_tx aud_ser_tx_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .fall_i(fall_w), .load_i(load_w),
  .pend_full_i(pend_full_w), .sdata_i(sdata_o), .valid_i(smp_valid_i),
  .ready_i(smp_ready_o), .underrun_i(underrun_o)
);

// File: tb/aud_ser_tx_bench.sv
module aud_ser_tx_bench;
  localparam int CH_W  = 24;
  localparam int NSLOT = 16;
  localparam int BUS_W = NSLOT * CH_W;
  localparam int NVEC  = 12;
  // [15:13] format, [12:11] width code, [10:9] slot code, [8:0] seed
  localparam logic [15:0] VEC [NVEC] = '{
    {3'd0, 2'd0, 2'd0, 9'd1},  {3'd0, 2'd2, 2'd0, 9'd2},
    {3'd1, 2'd0, 2'd0, 9'd3},  {3'd1, 2'd2, 2'd0, 9'd4},
    {3'd2, 2'd0, 2'd0, 9'd5},  {3'd2, 2'd1, 2'd0, 9'd6},
    {3'd2, 2'd2, 2'd0, 9'd7},  {3'd3, 2'd0, 2'd0, 9'd8},
    {3'd3, 2'd1, 2'd0, 9'd9},  {3'd4, 2'd0, 2'd0, 9'd10},
    {3'd4, 2'd1, 2'd1, 9'd11}, {3'd4, 2'd2, 2'd2, 9'd12}
  };

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic             rst_n = 1'b0, bclk = 1'b1, fclk = 1'b1, valid = 1'b0;
  logic [2:0]       fmt = 3'd0;
  logic [1:0]       width = 2'd0, slots = 2'd0;
  logic [BUS_W-1:0] data = '0;
  logic             ready, sdata, underrun;
  int               checks = 0, errors = 0, stab_err = 0;
  bit               done = 1'b0;

  aud_ser_tx u_aud_ser_tx (
    .clk_i(clk), .rst_ni(rst_n), .bclk_i(bclk), .fclk_i(fclk), .fmt_i(fmt),
    .width_i(width), .slots_i(slots), .smp_valid_i(valid), .smp_data_i(data),
    .smp_ready_o(ready), .sdata_o(sdata), .underrun_o(underrun)
  );

  function automatic logic [BUS_W-1:0] mk_smp(input int seed);
    logic [BUS_W-1:0] v;
    for (int c = 0; c < NSLOT; c++)
      v[c*CH_W +: CH_W] = 24'((seed * 1234567) ^ (c * 699053) ^ (seed << c));
    return v;
  endfunction

  function automatic int wbits(input int code);
    return (code == 1) ? 20 : (code == 2) ? 16 : 24;
  endfunction

  function automatic int nslots(input int code);
    return (code == 0) ? 4 : (code == 1) ? 8 : 16;
  endfunction

  function automatic logic exp_bit(input int f, input int wc, input int sc, input int p,
                                   input logic [BUS_W-1:0] s);
    int w, d, ch, k;
    w = wbits(wc);
    if (f == 4) begin
      if (p < 1) return 1'b0;
      ch = (p - 1) / 32;
      k  = (p - 1) % 32;
      if (ch >= nslots(sc) || k >= w) return 1'b0;
      return s[ch*CH_W + CH_W - 1 - k];
    end
    ch = p / 32;
    d  = (f == 1) ? 0 : (f == 2) ? 32 - w : 1;
    k  = (p % 32) - d;
    if (k < 0 || k >= w) return 1'b0;
    return s[ch*CH_W + CH_W - 1 - k];
  endfunction

  function automatic string tag_of(input int f, input int wc);
    string t;
    case (f)
      0: t = "R1 R3";
      1: t = "R4";
      2: t = "R5";
      3: t = "R7";
      default: t = "R8 R2";
    endcase
    if (wc != 0) t = {t, " R6"};
    return t;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic bit_cycle(input logic fv, output logic b);
    logic mid;
    @(negedge clk);
    bclk = 1'b0;
    fclk = fv;
    repeat (8) @(negedge clk);
    b = sdata;
    bclk = 1'b1;
    repeat (4) @(negedge clk);
    mid = sdata;
    repeat (4) @(negedge clk);
    if (mid !== b || sdata !== b) stab_err++;
  endtask

  task automatic push(input logic [BUS_W-1:0] s);
    while (!ready) @(negedge clk);
    @(negedge clk);
    valid = 1'b1;
    data  = s;
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic run_frame(input int f, input int wc, input int sc,
                           input logic [BUS_W-1:0] s, input string tag);
    int n, bad, first;
    logic b, eb, fv, fa, fe;
    bad = 0; first = -1; fa = 1'b0; fe = 1'b0;
    n = (f == 4) ? 32 * nslots(sc) : 64;
    bit_cycle((f >= 3) ? 1'b0 : 1'b1, b);
    for (int p = 0; p < n; p++) begin
      if (f <= 2)      fv = (p >= 32);
      else if (f == 3) fv = (p == 0 || p == 32);
      else             fv = (p == 0);
      bit_cycle(fv, b);
      eb = exp_bit(f, wc, sc, p, s);
      if (b !== eb) begin
        if (first < 0) begin first = p; fa = b; fe = eb; end
        bad++;
      end
    end
    chk(bad == 0, tag, $sformatf("frame fmt %0d w %0d s %0d, %0d bad bits, first at %0d",
        f, wc, sc, bad, first), longint'(fa), longint'(fe));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [BUS_W-1:0] a, bs, cs;
    repeat (5) @(negedge clk);
    chk(sdata == 1'b0 && ready == 1'b1 && underrun == 1'b0, "R1", "reset outputs",
        {sdata, ready, underrun}, 3'b010);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      logic [BUS_W-1:0] s;
      fmt   = VEC[i][15:13];
      width = VEC[i][12:11];
      slots = VEC[i][10:9];
      repeat (4) @(negedge clk);
      s = mk_smp(int'(VEC[i][8:0]));
      push(s);
      run_frame(int'(VEC[i][15:13]), int'(VEC[i][12:11]), int'(VEC[i][10:9]), s,
                tag_of(int'(VEC[i][15:13]), int'(VEC[i][12:11])));
    end
    chk(underrun == 1'b0, "R11", "no underrun when fed", underrun, 0);
    chk(stab_err == 0, "R9", "data stable in high phase", stab_err, 0);

    // handshake
    fmt = 3'd0; width = 2'd0; slots = 2'd0;
    repeat (4) @(negedge clk);
    a = mk_smp(100);
    push(a);
    chk(ready == 1'b0, "R2", "ready low while held", ready, 0);
    run_frame(0, 0, 0, a, "R2 R3");
    chk(ready == 1'b1, "R2", "ready after frame start", ready, 1);

    // underrun: repeat previous sample
    run_frame(0, 0, 0, a, "R11 repeat");
    chk(underrun == 1'b1, "R11", "underrun set", underrun, 1);

    // burst pause, flag stays set
    bs = mk_smp(200);
    push(bs);
    repeat (300) @(negedge clk);
    run_frame(0, 0, 0, bs, "R10 burst");
    chk(underrun == 1'b1, "R11", "underrun sticky", underrun, 1);

    // reset mid-run
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(sdata == 1'b0 && ready == 1'b1 && underrun == 1'b0, "R1", "reset mid-run",
        {sdata, ready, underrun}, 3'b010);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cs = mk_smp(300);
    push(cs);
    run_frame(0, 0, 0, cs, "R1 default");
    chk(underrun == 1'b0, "R1", "clean after reset", underrun, 0);
    chk(stab_err == 0, "R9", "data stable overall", stab_err, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule